// File: doc/BRIEF.md
# Multi-CPU Interrupt Enable and Acknowledge Controller

This block collects level-sensitive interrupt lines and decides, separately for each of up to four CPUs, which line that CPU should service next. A line reaches a CPU only when it is high, its global enable is on, the CPU's own mask for it is off, and its routing word names that CPU. Software never writes bitmaps to change enables or masks. It writes the number of one source to a set register or a clear register, so one write touches one source and needs no read-modify-write.

A per-source routing word chooses the CPUs that get the line, through a normal (IRQ) bit and a fast (FIQ) bit per CPU. Each CPU reads its own acknowledge register to learn the number of the lowest pending source, or an idle code. One source number is reserved for a private per-CPU line, such as a local timer. That line comes from a separate input for each CPU. The global enable and the routing word do not affect it; only the CPU's own mask gates it. Source numbers 0 and 1 are meant for the summary outputs of doorbell logic outside this block. Here they behave like any other global source.

Accesses use a simple request port. A `bus_local` flag picks between the per-CPU window and the global window, and `bus_cpu` names the CPU that makes the access.

Top module: `irq_dispatch`

## Requirements
- R1: After reset every source is disabled and masked for every CPU, and every routing word is zero. Each CPU's acknowledge register reads 1023, all `cpu_irq` and `cpu_fiq` bits are low, and routing words read 0.
- R2: A read of global offset 0x000 returns NUM_SRC in bits [11:2], with all other bits zero.
- R3: Writing a source number to global offset 0x030 sets that source's global enable. Writing it to global offset 0x034 clears the enable.
- R4: Writing a source number to per-CPU offset 0x048 masks that source for the CPU on `bus_cpu` only. Writing it to offset 0x04C unmasks it for that CPU only.
- R5: A source number of NUM_SRC or more written to any of the four set/clear offsets changes nothing. A routing write beyond the last source word also changes nothing.
- R6: Each source ID has a routing word at global offset 0x100 + 4*ID. Bit n routes the source to CPU n as IRQ, and bit 8+n routes it to CPU n as FIQ. The word reads back with all other bits zero.
- R7: A read of per-CPU offset 0x044 returns, in bits [9:0], the lowest eligible source ID for the accessing CPU, or 1023 if no source is eligible; bits [31:10] are zero. A source is eligible for CPU n when its line is high, it is enabled, it is unmasked for CPU n, and bit n or bit 8+n of its routing word is set.
- R8: Sources are level-sensitive. Reading the acknowledge register clears nothing, and a source stops being reported once its line drops.
- R9: Source PRIV_ID (default 5) takes its level for CPU n from `priv_level[n]` and is gated only by CPU n's mask. The global enable, the routing word and `src_level[PRIV_ID]` have no effect on it, and it is delivered as IRQ.
- R10: `cpu_irq[n]` is high one cycle after some source is eligible for CPU n through its IRQ bit, or the private line is eligible for CPU n. `cpu_fiq[n]` is high one cycle after some source is eligible for CPU n through its FIQ bit.
- R11: Every read request gets `bus_rvalid` and its data one cycle later. Writes never raise `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_local | input | 1 | 1 = per-CPU window, 0 = global window |
| bus_cpu | input | CPU_W | CPU making the access |
| bus_addr | input | ADDR_W | Byte offset within the chosen window |
| bus_wdata | input | 32 | Write data (source number or routing word) |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned, one cycle after the request |
| src_level | input | NUM_SRC | Level of each shared source line |
| priv_level | input | NUM_CPU | Private per-CPU line, one for each CPU |
| cpu_irq | output | NUM_CPU | Normal interrupt request for each CPU |
| cpu_fiq | output | NUM_CPU | Fast interrupt request for each CPU |

## Verification
The assertions assume that the bus inputs stay quiet until the internal reset has been released. They also assume that `bus_cpu` names an implemented CPU whenever a mask register is written. The stimulus waits several cycles after reset before its first access and draws CPU numbers only below NUM_CPU. Source numbers are drawn both inside and beyond the implemented range, so the ignored cases occur as well. Lines change only between accesses, and every check waits until the registered outputs have taken up the change.

// File: rtl/icx_pkg.sv
package icx_pkg;
  localparam int ID_W    = 10;
  localparam logic [ID_W-1:0] ID_IDLE = 10'd1023;
  localparam int FIQ_LSB = 8;

  // global window offsets
  localparam int A_CTRL     = 'h000;
  localparam int A_EN_SET   = 'h030;
  localparam int A_EN_CLR   = 'h034;
  localparam int A_SRC_BASE = 'h100;
  // per-CPU window offsets
  localparam int A_ACK      = 'h044;
  localparam int A_MSK_SET  = 'h048;
  localparam int A_MSK_CLR  = 'h04C;

  typedef enum logic [2:0] {
    WR_NONE, WR_EN_SET, WR_EN_CLR, WR_MSK_SET, WR_MSK_CLR, WR_ROUTE
  } wr_op_e;

  typedef enum logic [1:0] {
    RD_ZERO, RD_CTRL, RD_ACK, RD_ROUTE
  } rd_sel_e;
endpackage

// File: rtl/icx_decode.sv
module icx_decode
  import icx_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int SRC_W   = 5,
  parameter int CPU_W   = 2
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_local,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output wr_op_e            wr_op,
  output logic [SRC_W-1:0]  wr_idx,
  output logic [SRC_W-1:0]  route_idx,
  output logic              rd_req,
  output rd_sel_e           rd_sel
);
  logic [ADDR_W-1:0] rel;
  logic              cpu_ok;
  logic              idx_in;
  logic              win_hit;

  always_comb begin
    rel       = bus_addr - ADDR_W'(A_SRC_BASE);
    cpu_ok    = 32'(bus_cpu) < 32'(NUM_CPU);
    idx_in    = bus_wdata < 32'(NUM_SRC);
    win_hit   = (32'(bus_addr) >= 32'(A_SRC_BASE)) && (rel[1:0] == 2'b00) &&
                (32'(rel[ADDR_W-1:2]) < 32'(NUM_SRC));
    wr_idx    = bus_wdata[SRC_W-1:0];
    route_idx = rel[SRC_W+1:2];
    rd_req    = bus_valid && !bus_write;
    wr_op     = WR_NONE;
    rd_sel    = RD_ZERO;

    if (bus_valid && bus_write) begin
      if (bus_local) begin
        if (cpu_ok && idx_in) begin
          if (bus_addr == ADDR_W'(A_MSK_SET))      wr_op = WR_MSK_SET;
          else if (bus_addr == ADDR_W'(A_MSK_CLR)) wr_op = WR_MSK_CLR;
        end
      end else begin
        if (bus_addr == ADDR_W'(A_EN_SET) && idx_in)      wr_op = WR_EN_SET;
        else if (bus_addr == ADDR_W'(A_EN_CLR) && idx_in) wr_op = WR_EN_CLR;
        else if (win_hit)                                 wr_op = WR_ROUTE;
      end
    end

    if (rd_req) begin
      if (bus_local) begin
        if (cpu_ok && bus_addr == ADDR_W'(A_ACK)) rd_sel = RD_ACK;
      end else begin
        if (bus_addr == ADDR_W'(A_CTRL)) rd_sel = RD_CTRL;
        else if (win_hit)                rd_sel = RD_ROUTE;
      end
    end
  end
endmodule

// File: rtl/icx_state.sv
module icx_state
  import icx_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int SRC_W   = 5,
  parameter int CPU_W   = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  wr_op_e                            wr_op,
  input  logic [SRC_W-1:0]                  wr_idx,
  input  logic [SRC_W-1:0]                  route_idx,
  input  logic [CPU_W-1:0]                  wr_cpu,
  input  logic [NUM_CPU-1:0]                wd_irq,
  input  logic [NUM_CPU-1:0]                wd_fiq,
  output logic [NUM_SRC-1:0]                en_q,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_q,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   irq_rt_q,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   fiq_rt_q
);
  logic [NUM_SRC-1:0]              en_d;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] irq_rt_d;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] fiq_rt_d;
  logic                            st_we;

  always_comb begin
    en_d     = en_q;
    mask_d   = mask_q;
    irq_rt_d = irq_rt_q;
    fiq_rt_d = fiq_rt_q;
    st_we    = (wr_op != WR_NONE);
    case (wr_op)
      WR_EN_SET:  en_d[wr_idx] = 1'b1;
      WR_EN_CLR:  en_d[wr_idx] = 1'b0;
      WR_MSK_SET: mask_d[wr_cpu][wr_idx] = 1'b1;
      WR_MSK_CLR: mask_d[wr_cpu][wr_idx] = 1'b0;
      WR_ROUTE: begin
        irq_rt_d[route_idx] = wd_irq;
        fiq_rt_d[route_idx] = wd_fiq;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      mask_q   <= '1;
      irq_rt_q <= '0;
      fiq_rt_q <= '0;
    end else if (st_we) begin
      en_q     <= en_d;
      mask_q   <= mask_d;
      irq_rt_q <= irq_rt_d;
      fiq_rt_q <= fiq_rt_d;
    end
  end
endmodule

// File: rtl/icx_pick.sv
module icx_pick
  import icx_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIV_ID = 5
) (
  input  logic [NUM_SRC-1:0] level,
  input  logic               priv,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] irq_col,
  input  logic [NUM_SRC-1:0] fiq_col,
  output logic [ID_W-1:0]    ack_id,
  output logic               want_irq,
  output logic               want_fiq
);
  // scan from the top down so the lowest eligible ID is the last one kept
  always_comb begin
    logic is_priv, live, hit_i, hit_f;
    ack_id   = ID_IDLE;
    want_irq = 1'b0;
    want_fiq = 1'b0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      is_priv = (s == PRIV_ID);
      live    = is_priv ? (priv & ~mask[s]) : (level[s] & en[s] & ~mask[s]);
      hit_i   = live & (is_priv | irq_col[s]);
      hit_f   = live & ~is_priv & fiq_col[s];
      if (hit_i | hit_f) ack_id = ID_W'(s);
      want_irq = want_irq | hit_i;
      want_fiq = want_fiq | hit_f;
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import icx_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int PRIV_ID = 5,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_local,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [NUM_CPU-1:0] priv_level,
  output logic [NUM_CPU-1:0] cpu_irq,
  output logic [NUM_CPU-1:0] cpu_fiq
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  wr_op_e                          wr_op;
  rd_sel_e                         rd_sel;
  logic [SRC_W-1:0]                wr_idx, route_idx;
  logic                            rd_req;
  logic [NUM_SRC-1:0]              en_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] irq_rt_q, fiq_rt_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] irq_col, fiq_col;
  logic [NUM_CPU-1:0][ID_W-1:0]    ack_all;
  logic [NUM_CPU-1:0]              want_irq, want_fiq;
  logic [31:0]                     rdata_d;

  icx_decode #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W),
               .SRC_W(SRC_W), .CPU_W(CPU_W)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_local(bus_local),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wr_op(wr_op), .wr_idx(wr_idx), .route_idx(route_idx),
    .rd_req(rd_req), .rd_sel(rd_sel)
  );

  icx_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .SRC_W(SRC_W),
              .CPU_W(CPU_W)) u_state (
    .clk(clk), .rst_n(rst_sync_n), .wr_op(wr_op), .wr_idx(wr_idx),
    .route_idx(route_idx), .wr_cpu(bus_cpu),
    .wd_irq(bus_wdata[NUM_CPU-1:0]), .wd_fiq(bus_wdata[FIQ_LSB +: NUM_CPU]),
    .en_q(en_q), .mask_q(mask_q), .irq_rt_q(irq_rt_q), .fiq_rt_q(fiq_rt_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign irq_col[c][s] = irq_rt_q[s][c];
      assign fiq_col[c][s] = fiq_rt_q[s][c];
    end
    icx_pick #(.NUM_SRC(NUM_SRC), .PRIV_ID(PRIV_ID)) u_pick (
      .level(src_level), .priv(priv_level[c]), .en(en_q), .mask(mask_q[c]),
      .irq_col(irq_col[c]), .fiq_col(fiq_col[c]), .ack_id(ack_all[c]),
      .want_irq(want_irq[c]), .want_fiq(want_fiq[c])
    );
  end

  always_comb begin
    rdata_d = '0;
    case (rd_sel)
      RD_CTRL:  rdata_d[11:2] = ID_W'(NUM_SRC);
      RD_ACK:   rdata_d[ID_W-1:0] = ack_all[bus_cpu];
      RD_ROUTE: begin
        rdata_d[NUM_CPU-1:0]          = irq_rt_q[route_idx];
        rdata_d[FIQ_LSB +: NUM_CPU]   = fiq_rt_q[route_idx];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cpu_irq    <= '0;
      cpu_fiq    <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      cpu_irq    <= want_irq;
      cpu_fiq    <= want_fiq;
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import icx_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int SRC_W   = 5,
  parameter int CPU_W   = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_valid,
  input logic                            bus_write,
  input logic                            bus_local,
  input logic [CPU_W-1:0]                bus_cpu,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [31:0]                     bus_wdata,
  input logic                            bus_rvalid,
  input logic [NUM_SRC-1:0]              src_level,
  input logic [NUM_CPU-1:0]              priv_level,
  input logic [NUM_CPU-1:0]              cpu_irq,
  input logic [NUM_SRC-1:0]              en_q,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q
);
  logic g_wr, l_wr, in_rng;
  assign g_wr   = bus_valid && bus_write && !bus_local;
  assign l_wr   = bus_valid && bus_write && bus_local && (32'(bus_cpu) < 32'(NUM_CPU));
  assign in_rng = bus_wdata < 32'(NUM_SRC);

  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    g_wr && in_rng && bus_addr == ADDR_W'(A_EN_SET)
      |=> en_q[$past(bus_wdata[SRC_W-1:0])]);

  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    g_wr && in_rng && bus_addr == ADDR_W'(A_EN_CLR)
      |=> !en_q[$past(bus_wdata[SRC_W-1:0])]);

  assert_msk_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l_wr && in_rng && bus_addr == ADDR_W'(A_MSK_SET)
      |=> mask_q[$past(bus_cpu)][$past(bus_wdata[SRC_W-1:0])]);

  assert_msk_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l_wr && in_rng && bus_addr == ADDR_W'(A_MSK_CLR)
      |=> !mask_q[$past(bus_cpu)][$past(bus_wdata[SRC_W-1:0])]);

  assert_en_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    g_wr && !in_rng && (bus_addr == ADDR_W'(A_EN_SET) || bus_addr == ADDR_W'(A_EN_CLR))
      |=> $stable(en_q));

  assert_msk_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_local && !in_rng |=> $stable(mask_q));

  assert_irq_needs_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_irq) |-> $past((|src_level) || (|priv_level)));

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write |=> bus_rvalid);

  assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind irq_dispatch irq_dispatch_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W),
  .SRC_W(SRC_W), .CPU_W(CPU_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_local(bus_local), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .src_level(src_level),
  .priv_level(priv_level), .cpu_irq(cpu_irq), .en_q(en_q), .mask_q(mask_q)
);

// File: tb/irq_dispatch_test.sv
`timescale 1ns/1ps
module irq_dispatch_test;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int PRIV = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_valid, bus_write, bus_local;
  logic [1:0] bus_cpu;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_rvalid;
  logic [NS-1:0] src_level;
  logic [NC-1:0] priv_level, cpu_irq, cpu_fiq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model
  logic [NS-1:0] en_m;
  logic [NS-1:0] mask_m [NC];
  logic [NC-1:0] irq_m [NS];
  logic [NC-1:0] fiq_m [NS];

  always #4 clk = ~clk;

  irq_dispatch #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(12), .PRIV_ID(PRIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_local(bus_local), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .src_level(src_level), .priv_level(priv_level),
    .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit elig(int s, int c);
    if (s == PRIV) return priv_level[c] && !mask_m[c][s];
    return src_level[s] && en_m[s] && !mask_m[c][s] && (irq_m[s][c] || fiq_m[s][c]);
  endfunction

  function automatic int exp_ack(int c);
    for (int s = 0; s < NS; s++) if (elig(s, c)) return s;
    return 1023;
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        if (elig(s, c) && (s == PRIV || irq_m[s][c])) r[c] = 1'b1;
    return r;
  endfunction

  function automatic logic [NC-1:0] exp_fiq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        if (s != PRIV && elig(s, c) && fiq_m[s][c]) r[c] = 1'b1;
    return r;
  endfunction

  task automatic bus_wr(input bit loc, input int cpu, input int addr, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_local = loc;
    bus_cpu = 2'(cpu); bus_addr = 12'(addr); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input bit loc, input int cpu, input int addr,
                        output logic [31:0] d, output logic rv);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_local = loc;
    bus_cpu = 2'(cpu); bus_addr = 12'(addr);
    @(negedge clk);
    d = bus_rdata; rv = bus_rvalid;
    bus_valid = 0;
  endtask

  task automatic do_en(input bit set, input int idx);
    bus_wr(0, 0, set ? 'h30 : 'h34, 32'(idx));
    if (idx < NS) en_m[idx] = set;
  endtask

  task automatic do_mask(input bit set, input int c, input int idx);
    bus_wr(1, c, set ? 'h48 : 'h4C, 32'(idx));
    if (idx < NS) mask_m[c][idx] = set;
  endtask

  task automatic do_route(input int idx, input logic [31:0] d);
    bus_wr(0, 0, 'h100 + 4 * idx, d);
    if (idx < NS) begin
      irq_m[idx] = d[NC-1:0];
      fiq_m[idx] = d[8 +: NC];
    end
  endtask

  task automatic ack_of(input int c, output int id);
    logic [31:0] d; logic rv;
    bus_rd(1, c, 'h44, d, rv);
    id = int'(d);
  endtask

  task automatic check_all(input string req);
    int id;
    @(negedge clk);
    chk({req, " irq"}, 32'(cpu_irq), 32'(exp_irq()));
    chk({req, " fiq"}, 32'(cpu_fiq), 32'(exp_fiq()));
    for (int c = 0; c < NC; c++) begin
      ack_of(c, id);
      chk({req, " ack"}, 32'(id), 32'(exp_ack(c)));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic rv; int id;
    void'($urandom(32'd4242));
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_local = 0; bus_cpu = 0;
    bus_addr = 0; bus_wdata = 0; src_level = 0; priv_level = 0;
    en_m = '0;
    for (int c = 0; c < NC; c++) mask_m[c] = '1;
    for (int s = 0; s < NS; s++) begin irq_m[s] = '0; fiq_m[s] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(cpu_irq), 0);
    chk("R1 fiq", 32'(cpu_fiq), 0);
    for (int c = 0; c < NC; c++) begin ack_of(c, id); chk("R1 ack", 32'(id), 1023); end
    bus_rd(0, 0, 'h100 + 4 * 3, d, rv);
    chk("R1 route word", d, 0);
    chk("R11 rvalid on read", 32'(rv), 1);

    // R2 control register
    bus_rd(0, 0, 'h000, d, rv);
    chk("R2 ctrl", d, 32'(NS) << 2);

    // R11 writes give no rvalid
    do_route(9, 32'h1);
    chk("R11 no rvalid on write", 32'(bus_rvalid), 0);

    // R7 / R3 / R6 / R10
    do_route(3, 32'h100);
    do_mask(0, 0, 3); do_mask(0, 0, 9);
    do_en(1, 9);
    src_level[3] = 1; src_level[9] = 1;
    repeat (2) @(negedge clk);
    ack_of(0, id); chk("R3 only enabled source", 32'(id), 9);
    chk("R10 irq cpu0", 32'(cpu_irq), 32'h1);
    chk("R10 fiq idle", 32'(cpu_fiq), 0);
    do_en(1, 3);
    repeat (2) @(negedge clk);
    ack_of(0, id); chk("R7 lowest wins", 32'(id), 3);
    chk("R10 fiq cpu0", 32'(cpu_fiq), 32'h1);
    bus_rd(0, 0, 'h100 + 4 * 3, d, rv);
    chk("R6 route readback", d, 32'h100);

    // R8 level sensitive
    ack_of(0, id); chk("R8 ack not clearing", 32'(id), 3);
    src_level[3] = 0;
    repeat (2) @(negedge clk);
    ack_of(0, id); chk("R8 level dropped", 32'(id), 9);

    // R4 per-CPU masks
    do_route(9, 32'h3);
    ack_of(1, id); chk("R4 cpu1 still masked", 32'(id), 1023);
    do_mask(0, 1, 9);
    ack_of(1, id); chk("R4 cpu1 unmasked", 32'(id), 9);
    do_mask(1, 0, 9);
    ack_of(0, id); chk("R4 cpu0 masked", 32'(id), 1023);
    ack_of(1, id); chk("R4 cpu1 unaffected", 32'(id), 9);

    // R5 out-of-range numbers
    bus_wr(0, 0, 'h34, 32'(9 + NS));
    ack_of(1, id); chk("R5 enable clear ignored", 32'(id), 9);
    bus_wr(1, 1, 'h48, 32'(9 + NS));
    ack_of(1, id); chk("R5 mask set ignored", 32'(id), 9);
    bus_wr(0, 0, 'h100 + 4 * NS, 32'hF);
    bus_rd(0, 0, 'h100 + 4 * NS, d, rv);
    chk("R5 route beyond window", d, 0);
    do_en(0, 9);
    ack_of(1, id); chk("R3 enable cleared", 32'(id), 1023);

    // R9 private line
    priv_level[2] = 1;
    repeat (2) @(negedge clk);
    ack_of(2, id); chk("R9 private masked", 32'(id), 1023);
    do_mask(0, 2, PRIV);
    repeat (2) @(negedge clk);
    ack_of(2, id); chk("R9 private unmasked", 32'(id), PRIV);
    chk("R9 private irq", 32'(cpu_irq[2]), 1);
    src_level[PRIV] = 1;
    do_en(1, PRIV); do_route(PRIV, 32'h1); do_mask(0, 0, PRIV);
    ack_of(0, id); chk("R9 shared line ignored", 32'(id), 1023);
    check_all("R9 model");

    // constrained random phase
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      int idx = ($urandom_range(0, 9) == 0) ? NS + $urandom_range(0, 40)
                                             : $urandom_range(0, NS - 1);
      int c = $urandom_range(0, NC - 1);
      case (op)
        0: do_en(1, idx);
        1: do_en(0, idx);
        2: do_mask(1, c, idx);
        3: do_mask(0, c, idx);
        4: do_route(idx, $urandom & 32'h0F0F);
        default: begin
          @(negedge clk);
          src_level = $urandom & $urandom;
          priv_level = 4'($urandom);
        end
      endcase
      @(negedge clk);
      check_all("R7 R10 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule